// File: doc/BRIEF.md
# Table-Increment Code Histogram Engine

This block builds a per-code histogram of converter samples in one synchronous single-port memory, and it has no adder. The memory's top address bit splits it into two halves. The low half holds one count for each sample code. The high half holds an increment table that software preloads so that entry `n` contains `n+1`. To add a sample to its bin, the engine first reads the bin. It then uses the returned count as an address into the table half, catches the result in a holding register, and writes that result back to the bin.

Samples enter a buffer that absorbs bursts. The update sequencer drains the buffer more slowly than samples can arrive, because each update takes several memory accesses. Counts keep accumulating across any number of buffer fills until a clear pass zeroes every bin. A clear pass does not disturb the table. A raw mode sends samples straight to an output register and builds no histogram. A readout port returns any single bin through the same holding register.

Top module: `lut_histogram_engine`

## Requirements
- R1: After reset, `busy`, `ovf`, `rd_valid` and `raw_valid` are 0, and `done` is 1.
- R2: While the engine is idle and `clr_start` is low, a `tbl_we` cycle writes `tbl_data` into table entry `tbl_addr`. A `tbl_we` cycle is ignored while `busy` is high.
- R3: Each buffered sample with code `c` replaces bin `c` with the table entry addressed by the bin's old count. With the standard table this adds one. Changing table entry `k` changes the result for a bin that holds `k`.
- R4: Each update that does not saturate keeps `busy` high for exactly 3 cycles, so one sample is retired every 4 cycles.
- R5: Bins keep accumulating across separate bursts of samples until a clear pass runs.
- R6: A sample whose bin already holds the maximum count (2^CNT_W-1) leaves the bin unchanged and sets `ovf`. `ovf` stays set until a clear pass is started.
- R7: A `clr_start` pulse while idle keeps `busy` high for exactly 2^CODE_W cycles, writes 0 to every bin, clears `ovf` and leaves the table intact.
- R8: An `rd_en` request accepted while idle makes `rd_valid` high for exactly one cycle, after the second rising edge, with `rd_count` equal to the bin at `rd_addr`. Requests made while `busy` is high are ignored.
- R9: With `raw_mode` high, a valid sample appears on `raw_data` with `raw_valid` high one cycle later, and it does not change any bin. `raw_valid` is low in any cycle after no raw sample was offered.
- R10: `done` is high exactly when the engine is idle and the sample buffer is empty.
- R11: In histogram mode the buffer accepts at most FIFO_DEPTH samples before `smp_ready` goes low. A sample offered while `smp_ready` is low is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_mode | input | 1 | 1: pass samples straight through, 0: histogram them |
| smp_valid | input | 1 | Sample strobe |
| smp_code | input | CODE_W | Sample code |
| smp_ready | output | 1 | Buffer can take a sample (always 1 in raw mode) |
| raw_valid | output | 1 | Raw sample output valid |
| raw_data | output | CODE_W | Raw sample output |
| tbl_we | input | 1 | Table preload write strobe |
| tbl_addr | input | CNT_W | Table entry index |
| tbl_data | input | CNT_W | Table entry value |
| clr_start | input | 1 | Start a pass that zeroes every bin |
| rd_en | input | 1 | Bin readout request |
| rd_addr | input | CODE_W | Bin to read |
| rd_valid | output | 1 | Readout data valid (one-cycle pulse) |
| rd_count | output | CNT_W | Readout bin count |
| busy | output | 1 | Sequencer not idle |
| done | output | 1 | Idle with empty buffer |
| ovf | output | 1 | Sticky saturation flag |

## Verification
A corrupted sequencer state or holding register shows up as a wrong bin value at the next readout, which comes two cycles after the request. A bad step count shows up in the same update, as the number of cycles `busy` stays high. A lost or duplicated buffer pointer shows up as a mismatch when every bin is compared against a software histogram after a random burst, and as a wrong acceptance count when the buffer is filled behind a clear pass. Writing into the wrong half of the memory shows up on the next sample, whose bin then takes an unexpected table value.

// File: rtl/hist_pkg.sv
package hist_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_BIN,
        ST_RD_LUT,
        ST_WR_BIN,
        ST_CLEAR,
        ST_RDOUT
    } seq_state_e;
endpackage

// File: rtl/hist_fifo.sv
module hist_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int PW = $clog2(DEPTH);

    typedef struct packed {
        logic [PW:0] wp;
        logic [PW:0] rp;
    } ptr_t;

    ptr_t         r_q, r_d;
    logic [W-1:0] mem [DEPTH];

    assign empty = (r_q.wp == r_q.rp);
    assign full  = (r_q.wp[PW] != r_q.rp[PW]) && (r_q.wp[PW-1:0] == r_q.rp[PW-1:0]);
    assign dout  = mem[r_q.rp[PW-1:0]];

    always_comb begin
        r_d = r_q;
        if (push && !full) r_d.wp = r_q.wp + 1'b1;
        if (pop && !empty) r_d.rp = r_q.rp + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_ff @(posedge clk) begin
        if (push && !full) mem[r_q.wp[PW-1:0]] <= din;
    end
endmodule

// File: rtl/hist_ram.sv
module hist_ram #(
    parameter int AW = 11,
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        rdata <= mem[addr];
    end
endmodule

// File: rtl/hist_seq.sv
module hist_seq
    import hist_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_empty,
    input  logic [CODE_W-1:0] fifo_head,
    output logic              fifo_pop,
    input  logic              clr_start,
    input  logic              tbl_we,
    input  logic [CNT_W-1:0]  tbl_addr,
    input  logic [CNT_W-1:0]  tbl_data,
    input  logic              rd_en,
    input  logic [CODE_W-1:0] rd_addr,
    input  logic [CNT_W-1:0]  ram_rdata,
    output logic              ram_we,
    output logic [((CODE_W > CNT_W) ? CODE_W : CNT_W):0] ram_addr,
    output logic [CNT_W-1:0]  ram_wdata,
    output logic              busy,
    output logic              ovf,
    output logic              rd_valid,
    output logic [CNT_W-1:0]  rd_count
);
    localparam int IW = (CODE_W > CNT_W) ? CODE_W : CNT_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        seq_state_e        state;
        logic [CODE_W-1:0] smp;
        logic [CNT_W-1:0]  hold;
        logic [CODE_W-1:0] clr_idx;
        logic              ovf;
        logic              rd_valid;
    } seq_t;

    seq_t r_q, r_d;

    always_comb begin
        r_d          = r_q;
        r_d.rd_valid = 1'b0;
        ram_we       = 1'b0;
        ram_addr     = '0;
        ram_wdata    = '0;
        fifo_pop     = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (clr_start) begin
                    r_d.state   = ST_CLEAR;
                    r_d.clr_idx = '0;
                    r_d.ovf     = 1'b0;
                end else if (tbl_we) begin
                    ram_we    = 1'b1;
                    ram_addr  = {1'b1, IW'(tbl_addr)};
                    ram_wdata = tbl_data;
                end else if (rd_en) begin
                    ram_addr  = {1'b0, IW'(rd_addr)};
                    r_d.state = ST_RDOUT;
                end else if (!fifo_empty) begin
                    fifo_pop  = 1'b1;
                    r_d.smp   = fifo_head;
                    ram_addr  = {1'b0, IW'(fifo_head)};
                    r_d.state = ST_RD_BIN;
                end
            end
            ST_RD_BIN: begin
                // bin count is on the read bus: it becomes the table index
                r_d.hold = ram_rdata;
                if (ram_rdata == CNT_MAX) begin
                    r_d.ovf   = 1'b1;
                    r_d.state = ST_IDLE;
                end else begin
                    ram_addr  = {1'b1, IW'(ram_rdata)};
                    r_d.state = ST_RD_LUT;
                end
            end
            ST_RD_LUT: begin
                r_d.hold  = ram_rdata;
                r_d.state = ST_WR_BIN;
            end
            ST_WR_BIN: begin
                ram_we    = 1'b1;
                ram_addr  = {1'b0, IW'(r_q.smp)};
                ram_wdata = r_q.hold;
                r_d.state = ST_IDLE;
            end
            ST_CLEAR: begin
                ram_we   = 1'b1;
                ram_addr = {1'b0, IW'(r_q.clr_idx)};
                if (&r_q.clr_idx) r_d.state = ST_IDLE;
                else              r_d.clr_idx = r_q.clr_idx + 1'b1;
            end
            ST_RDOUT: begin
                r_d.hold     = ram_rdata;
                r_d.rd_valid = 1'b1;
                r_d.state    = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.state != ST_IDLE);
    assign ovf      = r_q.ovf;
    assign rd_valid = r_q.rd_valid;
    assign rd_count = r_q.hold;
endmodule

// File: rtl/lut_histogram_engine.sv
module lut_histogram_engine #(
    parameter int CODE_W     = 8,
    parameter int CNT_W      = 10,
    parameter int FIFO_DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raw_mode,
    input  logic              smp_valid,
    input  logic [CODE_W-1:0] smp_code,
    output logic              smp_ready,
    output logic              raw_valid,
    output logic [CODE_W-1:0] raw_data,
    input  logic              tbl_we,
    input  logic [CNT_W-1:0]  tbl_addr,
    input  logic [CNT_W-1:0]  tbl_data,
    input  logic              clr_start,
    input  logic              rd_en,
    input  logic [CODE_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [CNT_W-1:0]  rd_count,
    output logic              busy,
    output logic              done,
    output logic              ovf
);
    localparam int IW = (CODE_W > CNT_W) ? CODE_W : CNT_W;
    localparam int AW = IW + 1;

    typedef struct packed {
        logic              vld;
        logic [CODE_W-1:0] data;
    } raw_t;

    raw_t              raw_q, raw_d;
    logic              fifo_push, fifo_pop, fifo_full, fifo_empty;
    logic [CODE_W-1:0] fifo_head;
    logic              ram_we;
    logic [AW-1:0]     ram_addr;
    logic [CNT_W-1:0]  ram_wdata, ram_rdata;

    assign fifo_push = smp_valid && !raw_mode && !fifo_full;
    assign smp_ready = raw_mode || !fifo_full;

    hist_fifo #(.W(CODE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .din   (smp_code),
        .pop   (fifo_pop),
        .dout  (fifo_head),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    hist_ram #(.AW(AW), .DW(CNT_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    hist_seq #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_empty (fifo_empty),
        .fifo_head  (fifo_head),
        .fifo_pop   (fifo_pop),
        .clr_start  (clr_start),
        .tbl_we     (tbl_we),
        .tbl_addr   (tbl_addr),
        .tbl_data   (tbl_data),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .ram_rdata  (ram_rdata),
        .ram_we     (ram_we),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata),
        .busy       (busy),
        .ovf        (ovf),
        .rd_valid   (rd_valid),
        .rd_count   (rd_count)
    );

    always_comb begin
        raw_d      = raw_q;
        raw_d.vld  = raw_mode && smp_valid;
        if (raw_mode && smp_valid) raw_d.data = smp_code;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= raw_d;
    end

    assign raw_valid = raw_q.vld;
    assign raw_data  = raw_q.data;
    assign done      = !busy && fifo_empty;
endmodule

// File: rtl/hist_checker.sv
module hist_checker #(
    parameter int CODE_W = 8,
    parameter int CNT_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              raw_mode,
    input logic              smp_valid,
    input logic [CODE_W-1:0] smp_code,
    input logic              raw_valid,
    input logic [CODE_W-1:0] raw_data,
    input logic              tbl_we,
    input logic              clr_start,
    input logic              rd_valid,
    input logic              busy,
    input logic              done,
    input logic              ovf,
    input logic              ram_we,
    input logic              ram_tbl_bit
);
    a_r9_raw_echo: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_mode && smp_valid) |=> (raw_valid && raw_data == $past(smp_code)));

    a_r9_raw_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(raw_mode && smp_valid) |=> !raw_valid);

    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(clr_start && !busy)) |=> ovf);

    a_r7_clear_drops_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_start && !busy) |=> (!ovf && busy));

    a_r8_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r2_table_source: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && ram_tbl_bit) |-> (tbl_we && !busy && !clr_start));
endmodule

bind lut_histogram_engine hist_checker #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .raw_mode    (raw_mode),
    .smp_valid   (smp_valid),
    .smp_code    (smp_code),
    .raw_valid   (raw_valid),
    .raw_data    (raw_data),
    .tbl_we      (tbl_we),
    .clr_start   (clr_start),
    .rd_valid    (rd_valid),
    .busy        (busy),
    .done        (done),
    .ovf         (ovf),
    .ram_we      (ram_we),
    .ram_tbl_bit (ram_addr[AW-1])
);

// File: tb/lut_histogram_engine_bench.sv
`timescale 1ns/1ps
module lut_histogram_engine_bench;
    localparam int CODE_W = 8;
    localparam int CNT_W  = 10;
    localparam int DEPTH  = 64;
    localparam int BINS   = 1 << CODE_W;
    localparam int CMAX   = (1 << CNT_W) - 1;

    // {code, repeat count}
    localparam logic [15:0] VEC [8] = '{
        16'h0305, 16'h0A01, 16'h0303, 16'hFF02,
        16'h0004, 16'h8007, 16'h0A02, 16'h7F01
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              raw_mode = 1'b0;
    logic              smp_valid = 1'b0;
    logic [CODE_W-1:0] smp_code = '0;
    logic              smp_ready, raw_valid;
    logic [CODE_W-1:0] raw_data;
    logic              tbl_we = 1'b0;
    logic [CNT_W-1:0]  tbl_addr = '0, tbl_data = '0;
    logic              clr_start = 1'b0;
    logic              rd_en = 1'b0;
    logic [CODE_W-1:0] rd_addr = '0;
    logic              rd_valid, busy, done, ovf;
    logic [CNT_W-1:0]  rd_count;

    int n_chk = 0, n_fail = 0;
    int model [BINS];
    int busy_cnt = 0;
    bit cnt_en = 1'b0;

    always #4 clk = ~clk;

    lut_histogram_engine #(.CODE_W(CODE_W), .CNT_W(CNT_W), .FIFO_DEPTH(DEPTH)) u_lut_histogram_engine (
        .clk(clk), .rst_n(rst_n), .raw_mode(raw_mode), .smp_valid(smp_valid),
        .smp_code(smp_code), .smp_ready(smp_ready), .raw_valid(raw_valid),
        .raw_data(raw_data), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_data(tbl_data), .clr_start(clr_start), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_count(rd_count),
        .busy(busy), .done(done), .ovf(ovf)
    );

    always @(negedge clk) if (cnt_en && busy) busy_cnt++;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic push(input logic [CODE_W-1:0] c);
        while (!smp_ready) @(negedge clk);
        smp_valid = 1'b1;
        smp_code  = c;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic tbl_write(input int a, input int d);
        tbl_we = 1'b1; tbl_addr = CNT_W'(a); tbl_data = CNT_W'(d);
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic clear_pass();
        wait_done();
        clr_start = 1'b1;
        @(negedge clk);
        clr_start = 1'b0;
        wait_done();
    endtask

    task automatic read_bin(input int a, output int v);
        wait_done();
        rd_en = 1'b1; rd_addr = CODE_W'(a);
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
        v = rd_valid ? int'(rd_count) : -1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int v, acc, flag;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 ovf", ovf, 0);
        chk("R1 rd_valid", rd_valid, 0);
        chk("R1 raw_valid", raw_valid, 0);
        chk("R1 done", done, 1);

        // R2 preload table: entry n holds n+1
        for (int i = 0; i <= CMAX; i++) tbl_write(i, (i + 1) & CMAX);

        // R7 clear pass length
        busy_cnt = 0; cnt_en = 1'b1;
        clear_pass();
        cnt_en = 1'b0;
        chk("R7 clear cycles", busy_cnt, BINS);
        for (int i = 0; i < BINS; i++) model[i] = 0;

        // R3/R4 vector table walk
        busy_cnt = 0; cnt_en = 1'b1; acc = 0;
        for (int k = 0; k < 8; k++) begin
            for (int j = 0; j < int'(VEC[k][7:0]); j++) begin
                push(VEC[k][15:8]);
                model[VEC[k][15:8]]++;
                acc++;
            end
        end
        wait_done();
        cnt_en = 1'b0;
        chk("R4 busy cycles", busy_cnt, 3 * acc);
        for (int k = 0; k < 8; k++) begin
            read_bin(int'(VEC[k][15:8]), v);
            chk("R3 R8 bin", v, model[VEC[k][15:8]]);
        end

        // R5 second burst accumulates on top of the first
        for (int j = 0; j < 400; j++) begin
            int c;
            c = $urandom_range(BINS - 1, 0);
            push(CODE_W'(c));
            model[c]++;
        end
        wait_done();
        flag = 0;
        for (int i = 0; i < BINS; i++) begin
            read_bin(i, v);
            if (v != model[i]) flag++;
            if (v != model[i]) $display("FAIL R5 bin %0d: actual %0d expected %0d", i, v, model[i]);
        end
        chk("R5 accumulated bins mismatching", flag, 0);

        // R8/R2 requests while busy are ignored
        wait_done();
        clr_start = 1'b1;
        @(negedge clk);
        clr_start = 1'b0;
        rd_en = 1'b1; rd_addr = 8'h0A; tbl_we = 1'b1; tbl_addr = '0; tbl_data = 10'd7;
        @(negedge clk);
        rd_en = 1'b0; tbl_we = 1'b0;
        flag = 0;
        repeat (3) begin
            @(negedge clk);
            if (rd_valid) flag = 1;
        end
        chk("R8 rd ignored while busy", flag, 0);
        wait_done();
        read_bin(8'h0A, v);
        chk("R7 bin zeroed", v, 0);
        push(8'h11);
        read_bin(8'h11, v);
        chk("R2 table write ignored while busy", v, 1);

        // R3 the increment comes from the table
        tbl_write(1, 9);
        push(8'h11);
        read_bin(8'h11, v);
        chk("R3 table lookup", v, 9);
        tbl_write(1, 2);

        // R9 raw bypass
        raw_mode = 1'b1;
        smp_valid = 1'b1; smp_code = 8'h42;
        @(negedge clk);
        smp_valid = 1'b0;
        chk("R9 raw_valid", raw_valid, 1);
        chk("R9 raw_data", raw_data, 8'h42);
        chk("R10 done in raw", done, 1);
        @(negedge clk);
        chk("R9 raw_valid drops", raw_valid, 0);
        raw_mode = 1'b0;
        read_bin(8'h42, v);
        chk("R9 bin untouched", v, 0);

        // R11 buffer depth behind a clear pass
        clr_start = 1'b1;
        @(negedge clk);
        clr_start = 1'b0;
        acc = 0;
        for (int j = 0; j < DEPTH + 6; j++) begin
            if (smp_ready) acc++;
            smp_valid = 1'b1; smp_code = 8'h20;
            @(negedge clk);
        end
        smp_valid = 1'b0;
        chk("R11 accepted", acc, DEPTH);
        chk("R11 ready low when full", smp_ready, 0);
        chk("R10 done low with data", done, 0);
        wait_done();
        chk("R10 done after drain", done, 1);
        read_bin(8'h20, v);
        chk("R11 bin count", v, DEPTH);

        // R6 saturation
        clear_pass();
        for (int j = 0; j < CMAX; j++) push(8'h55);
        wait_done();
        chk("R6 no ovf at max", ovf, 0);
        read_bin(8'h55, v);
        chk("R6 bin at max", v, CMAX);
        push(8'h55);
        wait_done();
        chk("R6 ovf set", ovf, 1);
        read_bin(8'h55, v);
        chk("R6 bin held", v, CMAX);
        push(8'h56);
        wait_done();
        chk("R6 ovf sticky", ovf, 1);
        read_bin(8'h56, v);
        chk("R6 other bin", v, 1);
        clear_pass();
        chk("R7 clear drops ovf", ovf, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule